// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge

This block gathers up to 32 level-sensitive request lines from peripherals and drives a single interrupt output toward a host processor. Software reaches it through a small word-addressed register port with four 32-bit registers:

| Address | Register | Contents |
|---|---|---|
| 0 | control | enable bit, output level, channel routing, promoted source |
| 1 | vector | acknowledge bit on write, delivered vector on read |
| 2 | in-service | one bit per source currently being serviced |
| 3 | enable-mask | one bit per source allowed to interrupt |

The host acknowledges an interrupt in two steps. It first writes a 1 to bit 0 of the vector register. The block then captures the winning source number, and a following read of the same register returns that number in bits 15:11.

The winner is the highest-priority source that is requested, unmasked and not blocked by service already under way. The winning source is marked in service until software writes a 1 to its bit in the in-service register. If the request that raised the output has gone away or been masked by the time of the acknowledge, the block returns the reserved vector 0 and marks nothing in service.

Priority is fixed by source number: the higher number wins. One source may be promoted above all others through the control register. Four channel slots (sources `CH_BASE` to `CH_BASE+3`) take their requests from channel lines chosen by 2-bit routing fields. The register port is a plain control path with no flow control: each write takes effect at the clock edge where `reg_wr` is high, and reads are combinational.

Top module: `vec_intc`

## Requirements
- R1: After reset the enable-mask reads 0, the in-service register reads 0, the vector register reads 0, `irq_out` is low, and the control register reads 0x00E40000 (routing fields set to the identity map, enable off, level 0, no promotion).
- R2: Bit n of the enable-mask (address 3) set lets source n interrupt; bit n clear blocks it. Source 0 never interrupts, because vector 0 is reserved for the error vector.
- R3: Writing a 1 to bit 0 of the vector register (address 1) captures the highest-priority qualifying source. A read of address 1 then returns {16'b0, vector[4:0], 11'b0}.
- R4: Without promotion, the highest-numbered qualifying source wins. The control field in bits 28:24 names a promoted source that wins over all others whenever it qualifies; the value 0 disables promotion.
- R5: The 2-bit control field at bits 17+2k:16+2k selects which channel line `irq_in[CH_BASE+sel]` feeds slot source `CH_BASE+k`, for k = 0..3.
- R6: `irq_out` rises only while control bit 7 (global enable) is 1. It is the registered value, one cycle later, of "enable and a qualifying source exists".
- R7: The 3-bit field in control bits 15:13 appears on `irq_level`.
- R8: An acknowledge that delivers a nonzero vector v sets in-service bit v.
- R9: Writing to address 2 clears every in-service bit written as 1 and leaves bits written as 0 unchanged.
- R10: While any source is in service, only a source of strictly higher priority than the highest in-service one qualifies.
- R11: All requests are level-sensitive. If no source qualifies at the acknowledge, the vector is 0 and the in-service register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Level request lines |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 1 | Interrupt to host |
| irq_level | output | 3 | Host interrupt level for irq_out |

## Verification
The hardest case to reach is the masking race: a request must raise `irq_out` and then vanish before the acknowledge. The bench produces it by asserting one line, waiting until `irq_out` is seen high, dropping the line, and only then writing the acknowledge. It then checks that the vector is 0 and that the in-service register is untouched. Nested service is reached by acknowledging a low source first and then raising a lower and a higher line in turn.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] A_VEC   = 2'd1;
  localparam logic [REG_AW-1:0] A_INSVC = 2'd2;
  localparam logic [REG_AW-1:0] A_MASK  = 2'd3;
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_LVL_LSB  = 13;
  localparam int CTL_SLOT_LSB = 16;
  localparam int CTL_PRO_LSB  = 24;
  localparam int VEC_LSB      = 11;
  localparam int NSLOT        = 4;
endpackage

// File: rtl/vec_intc_route.sv
module vec_intc_route
  import vec_intc_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int CH_BASE = 24
) (
  input  logic [NSRC-1:0]    irq_in,
  input  logic [2*NSLOT-1:0] slot_sel,
  output logic [NSRC-1:0]    req
);
  logic [NSLOT-1:0] ch;
  assign ch = irq_in[CH_BASE +: NSLOT];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i >= CH_BASE && i < CH_BASE + NSLOT) begin : g_slot
      assign req[i] = ch[slot_sel[2*(i-CH_BASE) +: 2]];
    end else begin : g_pass
      assign req[i] = irq_in[i];
    end
  end
endmodule

// File: rtl/vec_intc_prio.sv
module vec_intc_prio #(
  parameter int NSRC = 32,
  localparam int VW = $clog2(NSRC),
  localparam int RW = VW + 1
) (
  input  logic [NSRC-1:0] vec,
  input  logic [VW-1:0]   promo,
  output logic            any,
  output logic [VW-1:0]   idx,
  output logic [RW-1:0]   rank
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = VW'(i);
      end
    end
    rank = any ? RW'(idx) : '0;
    if (promo != '0 && vec[promo]) begin
      idx  = promo;
      rank = RW'(NSRC);
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int CH_BASE = 24,
  localparam int VW = $clog2(NSRC),
  localparam int RW = VW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq_out,
  output logic [2:0]      irq_level
);
  logic                 en_q;
  logic [2:0]           lvl_q;
  logic [2*NSLOT-1:0]   slot_q;
  logic [VW-1:0]        pro_q;
  logic [NSRC-1:0]      mask_q, isr_q, req, pend;
  logic [VW-1:0]        vec_q;
  logic                 irq_q;
  logic                 p_any, s_any;
  logic [VW-1:0]        p_idx, s_idx;
  logic [RW-1:0]        p_rank, s_rank;
  logic                 qual, ack, eoi;
  logic [31:0]          ctrl_rd;

  vec_intc_route #(.NSRC(NSRC), .CH_BASE(CH_BASE)) u_route (
    .irq_in(irq_in), .slot_sel(slot_q), .req(req));

  assign pend = req & mask_q & {{(NSRC-1){1'b1}}, 1'b0};

  vec_intc_prio #(.NSRC(NSRC)) u_pend (
    .vec(pend), .promo(pro_q), .any(p_any), .idx(p_idx), .rank(p_rank));
  vec_intc_prio #(.NSRC(NSRC)) u_svc (
    .vec(isr_q), .promo(pro_q), .any(s_any), .idx(s_idx), .rank(s_rank));

  // s_any / s_idx only matter through s_rank
  assign qual = p_any && (p_rank > (s_any ? s_rank : RW'(0)));
  assign ack  = reg_wr && reg_addr == A_VEC && reg_wdata[0];
  assign eoi  = reg_wr && reg_addr == A_INSVC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lvl_q  <= '0;
      slot_q <= 8'hE4;
      pro_q  <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= en_q && qual;
      if (reg_wr && reg_addr == A_CTRL) begin
        en_q   <= reg_wdata[CTL_EN_BIT];
        lvl_q  <= reg_wdata[CTL_LVL_LSB +: 3];
        slot_q <= reg_wdata[CTL_SLOT_LSB +: 2*NSLOT];
        pro_q  <= reg_wdata[CTL_PRO_LSB +: VW];
      end
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NSRC-1:0];
      if (eoi) isr_q <= isr_q & ~reg_wdata[NSRC-1:0];
      if (ack) begin
        if (qual) begin
          vec_q        <= p_idx;
          isr_q[p_idx] <= 1'b1;
        end else begin
          vec_q <= '0;
        end
      end
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTL_EN_BIT]                = en_q;
    ctrl_rd[CTL_LVL_LSB +: 3]          = lvl_q;
    ctrl_rd[CTL_SLOT_LSB +: 2*NSLOT]   = slot_q;
    ctrl_rd[CTL_PRO_LSB +: VW]         = pro_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_rd;
      A_VEC:   reg_rdata[VEC_LSB +: VW] = vec_q;
      A_INSVC: reg_rdata[NSRC-1:0] = isr_q;
      default: reg_rdata[NSRC-1:0] = mask_q;
    endcase
  end

  assign irq_out   = irq_q;
  assign irq_level = lvl_q;

  // ---- assertions ----
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_out);
  assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_out);
  assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (vec_q == '0) || isr_q[vec_q]);
  assert_eoi_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> (isr_q & $past(reg_wdata[NSRC-1:0])) == '0);
  assert_err_nochg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !qual) |=> (vec_q == '0) && $stable(isr_q));
  assert_src0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_q[0]);
endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  logic [2:0]  irq_level;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  vec_intc u_vec_intc (.clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .irq_level(irq_level));

  // {irq_in, mask, ctrl, exp_irq_out, exp_vec}
  localparam int NV = 7;
  localparam logic [101:0] TBL [NV] = '{
    {32'h0000_0010, 32'hFFFF_FFFF, 32'h00E4_0080, 1'b1, 5'd4},   // R3
    {32'h8000_0110, 32'hFFFF_FFFF, 32'h00E4_0080, 1'b1, 5'd31},  // R4 fixed
    {32'h8000_0110, 32'h0000_0FFF, 32'h00E4_0080, 1'b1, 5'd8},   // R2 mask
    {32'h8000_0110, 32'hFFFF_FFFF, 32'h04E4_0080, 1'b1, 5'd4},   // R4 promote
    {32'h0000_0001, 32'hFFFF_FFFF, 32'h00E4_0080, 1'b0, 5'd0},   // R2 src0
    {32'h0100_0000, 32'h0800_0000, 32'h0027_0080, 1'b1, 5'd27},  // R5 routing
    {32'h0000_0010, 32'hFFFF_FFFF, 32'h00E4_0000, 1'b0, 5'd4}    // R6 gate
  };

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait2;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd3, d); chk("R1 mask", d, 32'h0);
    rd(2'd2, d); chk("R1 insvc", d, 32'h0);
    rd(2'd1, d); chk("R1 vec", d, 32'h0);
    rd(2'd0, d); chk("R1 ctrl", d, 32'h00E4_0000);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      irq_in = TBL[i][101:70];
      wr(2'd3, TBL[i][69:38]);
      wr(2'd0, TBL[i][37:6]);
      wait2;
      chk("R2/R4/R5/R6 irq_out", {31'b0, irq_out}, {31'b0, TBL[i][5]});
      wr(2'd1, 32'h1);
      rd(2'd1, d);
      chk("R3/R4/R5 vector", d, {16'b0, TBL[i][4:0], 11'b0});
      wr(2'd2, 32'hFFFF_FFFF);
      irq_in = '0;
    end

    // R7 level field
    wr(2'd0, 32'h00E4_A080);
    @(negedge clk);
    chk("R7 level", {29'b0, irq_level}, 32'd5);

    // R8 / R10 nesting
    wr(2'd3, 32'hFFFF_FFFF);
    irq_in = 32'h0000_0020;
    wait2;
    chk("R6 raise", {31'b0, irq_out}, 32'h1);
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R3 vec5", d, {16'b0, 5'd5, 11'b0});
    rd(2'd2, d); chk("R8 insvc5", d, 32'h0000_0020);
    wait2;
    chk("R10 blocked by self", {31'b0, irq_out}, 32'h0);
    irq_in = 32'h0000_0028;
    wait2;
    chk("R10 lower blocked", {31'b0, irq_out}, 32'h0);
    irq_in = 32'h0000_0228;
    wait2;
    chk("R10 higher passes", {31'b0, irq_out}, 32'h1);
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R10 vec9", d, {16'b0, 5'd9, 11'b0});
    rd(2'd2, d); chk("R8 insvc nested", d, 32'h0000_0220);
    // R9 partial end of interrupt
    wr(2'd2, 32'h0000_0200);
    rd(2'd2, d); chk("R9 partial clear", d, 32'h0000_0020);
    wr(2'd2, 32'h0000_0020);
    rd(2'd2, d); chk("R9 full clear", d, 32'h0);

    // R11 race: request vanishes before acknowledge
    irq_in = 32'h0000_0040;
    wait2;
    chk("R11 raised", {31'b0, irq_out}, 32'h1);
    irq_in = '0;
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R11 error vector", d, 32'h0);
    rd(2'd2, d); chk("R11 insvc unchanged", d, 32'h0);
    wait2;
    chk("R11 level drop", {31'b0, irq_out}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule